// File: doc/BRIEF.md
# Sequential Signed/Unsigned Radix-2 Booth Multiplier

This block multiplies two W-bit operands over W clock cycles, one recoding step per cycle, and returns the full 2W-bit product. It keeps three registers. The accumulator holds the high half of the product. The multiplier register gives up one bit per step and fills with low product bits from the top. The multiplicand register stays constant for the whole operation. A single-bit history register records the last bit shifted out of the multiplier register, so each step can look at two adjacent multiplier bits.

In signed mode, each step adds the multiplicand, subtracts it, or adds nothing, depending on the pair of bits examined. The accumulator then shifts right arithmetically into the multiplier register. In unsigned mode, a step adds either the multiplicand or zero, and the adder's carry-out enters the top of the accumulator.

A client pulses `go` while the unit is idle. It then waits for the one-cycle `fin` pulse and reads `prod`, which stays unchanged until the next accepted `go`.

Top module: `booth_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy` is 0, `fin` is 0 and `prod` is 0.
- R2: A `go` sampled high while `busy` is 0 is accepted. `busy` is 1 from the next cycle. `fin` rises exactly W clock edges after the accepting edge, lasts exactly one cycle, and `busy` falls in that same cycle.
- R3: With `uns` = 0 at acceptance, `prod` equals the signed two's-complement product of `x` and `y`, as a 2W-bit two's-complement value.
- R4: In signed mode, the most negative operand squared, -2^(W-1) × -2^(W-1), yields +2^(2W-2). For W = 8 this is 16'h4000.
- R5: With `uns` = 1 at acceptance, `prod` equals the unsigned product of `x` and `y`.
- R6: A `go` sampled while `busy` is 1 is ignored. The running operation keeps its operands and its completion cycle.
- R7: After `fin`, `prod` holds its value until the next accepted `go`, whatever `x`, `y` and `uns` do.
- R8: `uns`, `x` and `y` are sampled only at acceptance. Changing them during an operation does not alter its result.
- R9: The signed example -6 × -5 yields 30 (16'h001E for W = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, accepted only while idle |
| uns | input | 1 | 1 = unsigned shift-add mode, 0 = signed Booth mode |
| x | input | W | Multiplier operand |
| y | input | W | Multiplicand operand |
| busy | output | 1 | Operation in progress |
| fin | output | 1 | One-cycle completion pulse |
| prod | output | 2W | Product: high half from the accumulator, low half from the multiplier register |

## Verification
The bench builds the block with W = 8. This makes hand-computed 16-bit expected values practical, and it still reaches both extremes of the operand range: -128 squared, -128 × 127, and 255 × 255 in unsigned mode. With eight steps per operation there is enough room to inject a second request, and to flip the mode and operands, in the middle of a run. The completion pulse can then be checked cycle by cycle against the latency of W edges.

// File: rtl/booth_mul.sv
module booth_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           uns,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic           busy,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, mlr, mcd;
  logic          hist, mode;
  logic [CW-1:0] step;
  logic          add_en, sub_en;
  logic [W:0]    ext_acc, ext_mcd, opnd, sum;

  assign sub_en  = !mode && mlr[0] && !hist;
  assign add_en  = mode ? mlr[0] : (!mlr[0] && hist);
  assign ext_acc = {mode ? 1'b0 : acc[W-1], acc};
  assign ext_mcd = {mode ? 1'b0 : mcd[W-1], mcd};
  assign opnd    = sub_en ? ~ext_mcd : (add_en ? ext_mcd : '0);
  assign sum     = ext_acc + opnd + {{W{1'b0}}, sub_en};
  assign prod    = {acc, mlr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      mlr  <= '0;
      mcd  <= '0;
      hist <= 1'b0;
      mode <= 1'b0;
      step <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (go) begin
          acc  <= '0;
          mlr  <= x;
          mcd  <= y;
          hist <= 1'b0;
          mode <= uns;
          step <= '0;
          busy <= 1'b1;
        end
      end else begin
        acc  <= sum[W:1];
        mlr  <= {sum[0], mlr[W-1:1]};
        hist <= mlr[0];
        step <= step + 1'b1;
        if (step == CW'(W - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           go,
  input logic           uns,
  input logic [W-1:0]   x,
  input logic [W-1:0]   y,
  input logic           busy,
  input logic           fin,
  input logic [2*W-1:0] prod
);
  localparam int CW = $clog2(W + 2);

  logic [W-1:0]   rx, ry;
  logic           rmode;
  logic [CW-1:0]  steps;
  logic [2*W-1:0] ref_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx <= '0; ry <= '0; rmode <= 1'b0; steps <= '0;
    end else if (go && !busy) begin
      rx <= x; ry <= y; rmode <= uns; steps <= '0;
    end else if (busy) begin
      steps <= steps + 1'b1;
    end
  end

  always_comb begin
    if (rmode) ref_p = {{W{1'b0}}, rx} * {{W{1'b0}}, ry};
    else       ref_p = {{W{rx[W-1]}}, rx} * {{W{ry[W-1]}}, ry};
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);
  p_fin_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  p_fin_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy);
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> steps == CW'(W));
  p_signed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !rmode) |-> prod == ref_p);
  p_unsigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && rmode) |-> prod == ref_p);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(prod));
endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .uns(uns), .x(x), .y(y),
  .busy(busy), .fin(fin), .prod(prod)
);

// File: tb/test_booth_mul.sv
`timescale 1ns/1ps
module test_booth_mul;
  localparam int W = 8;
  localparam int NV = 12;
  localparam logic [2*W+2*W:0] VEC [NV] = '{
    {1'b0, 8'hFA, 8'hFB, 16'h001E},
    {1'b0, 8'h80, 8'h80, 16'h4000},
    {1'b0, 8'h7F, 8'h7F, 16'h3F01},
    {1'b0, 8'h80, 8'h7F, 16'hC080},
    {1'b0, 8'hFF, 8'h01, 16'hFFFF},
    {1'b0, 8'h00, 8'h9C, 16'h0000},
    {1'b0, 8'h55, 8'hAA, 16'hE372},
    {1'b0, 8'h07, 8'hFD, 16'hFFEB},
    {1'b1, 8'hFF, 8'hFF, 16'hFE01},
    {1'b1, 8'h80, 8'h80, 16'h4000},
    {1'b1, 8'hFA, 8'hFB, 16'hF51E},
    {1'b1, 8'h03, 8'h07, 16'h0015}
  };

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, uns = 1'b0;
  logic [W-1:0] x = '0, y = '0;
  logic busy, fin;
  logic [2*W-1:0] prod;
  int nchk = 0, nbad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  booth_mul #(.W(W)) i_booth_mul (
    .clk(clk), .rst_n(rst_n), .go(go), .uns(uns), .x(x), .y(y),
    .busy(busy), .fin(fin), .prod(prod)
  );

  task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic m, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [2*W-1:0] exp, input string req, input bit disturb);
    go = 1'b1; uns = m; x = a; y = b;
    @(negedge clk);
    go = 1'b0;
    chk("R2 busy after accept", {15'd0, busy}, 16'd1);
    for (int i = 1; i < W; i++) begin
      if (disturb && i == 3) begin
        go = 1'b1; uns = ~m; x = ~a; y = ~b;
      end
      @(negedge clk);
      go = 1'b0;
      if (fin !== 1'b0) chk("R2 R6 early fin", {15'd0, fin}, 16'd0);
    end
    @(negedge clk);
    chk("R2 fin on step W", {15'd0, fin}, 16'd1);
    chk("R2 busy low at fin", {15'd0, busy}, 16'd0);
    chk(req, prod, exp);
    x = 8'h5A; y = 8'hC3; uns = ~m;
    @(negedge clk);
    chk("R2 fin single cycle", {15'd0, fin}, 16'd0);
    @(negedge clk);
    chk("R7 product held", prod, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!ended) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 reset prod", prod, 16'h0000);
    chk("R1 reset busy/fin", {14'd0, busy, fin}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {14'd0, busy, fin}, 16'd0);
    for (int k = 0; k < NV; k++) begin
      logic [2*W+2*W:0] v;
      v = VEC[k];
      run(v[4*W], v[4*W-1:3*W], v[3*W-1:2*W], v[2*W-1:0],
          v[4*W] ? "R5 unsigned product" : "R3 signed product", 0);
    end
    run(1'b0, 8'hFA, 8'hFB, 16'h001E, "R9 -6 x -5", 0);
    run(1'b0, 8'h80, 8'h80, 16'h4000, "R4 most negative squared", 0);
    run(1'b0, 8'h55, 8'hAA, 16'hE372, "R6 R8 start and mode ignored while busy", 1);
    run(1'b1, 8'hFA, 8'hFB, 16'hF51E, "R6 R8 unsigned disturbed", 1);
    repeat (5) @(negedge clk);
    chk("R7 idle hold", prod, 16'hF51E);
    ended = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule